// File: doc/BRIEF.md
# Dual-Window Overlay Blender with Brightness Scaling

This block is one stage of a display pixel pipeline. Each accepted input beat carries a 32-bit framebuffer pixel and the pixel's row and column. Byte 0 to byte 2 of the pixel are its three colour channels and byte 3 is a weight byte. Two rectangular overlay windows can be laid over the frame. Each window has its own enable bit, top row, left column, width and height. When a pixel falls inside an enabled window, the block fetches that window's overlay pixel from an external overlay memory. It then mixes the overlay colour with the framebuffer colour, using the framebuffer's weight byte to set the mix.

After mixing, a global brightness level scales all three channels through a 16-entry table. The block produces a 24-bit colour beat with a valid/ready handshake. The window settings feed shadow registers, and these are loaded only on a frame-start pulse. Software can therefore rewrite the settings at any time without tearing the picture.

Top module: `ovl_blend_dim`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, ovl_rd_en is 0, and both windows count as disabled until the first frame_start pulse.
- R2: A pixel accepted on clock edge k (in_valid and in_ready both high) appears on out_valid/out_rgb after edge k+2, so it is visible after the third edge counted from acceptance and not after the second.
- R3: A pixel is inside window w when top ≤ row < top + height and left ≤ col < left + width. Both lower bounds are inclusive and both upper bounds are exclusive.
- R4: A window whose enable bit is 0 never affects a pixel.
- R5: Inside a window, with a = in_pixel[31:24], output channel i (out_rgb[8i+7:8i]) equals ((255 − a)·overlay_i + a·pixel_i) >> 8, truncated. Here pixel_i = in_pixel[8i+7:8i] and overlay_i = ovl_rd_data[8i+7:8i].
- R6: Outside every enabled window, out_rgb equals in_pixel[23:0] before brightness scaling, and the weight byte is dropped.
- R7: The overlay read goes to byte address w·0x400000 + ((row − top)·width + (col − left))·4, with ovl_rd_en high during the accepting cycle. The read data is used one clock later, and the memory holds its output while ovl_rd_en is low.
- R8: Window 0 is evaluated before window 1, so where both windows cover a pixel, window 1's overlay pixel is used.
- R9: When dim_level is below 15, each channel becomes (table[dim_level]·channel) >> 8. When dim_level is 15, no scaling is applied. The default table entry i equals 16·i.
- R10: Window settings take effect only on a clock edge where frame_start is high. Setting changes made without that pulse do not alter the output.
- R11: While out_valid is high and out_ready is low, out_rgb holds steady and in_ready is 0. Once out_ready returns, stalled pixels come out in order with none lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Loads the window settings into the shadow registers |
| win_en | input | NUM_WIN | Per-window enable, window w at bit w |
| win_top | input | NUM_WIN·ROW_W | Per-window top row, window w at slice w |
| win_left | input | NUM_WIN·COL_W | Per-window left column |
| win_width | input | NUM_WIN·COL_W | Per-window width in pixels |
| win_height | input | NUM_WIN·ROW_W | Per-window height in rows |
| dim_level | input | LVL_W | Brightness level; the all-ones value means full brightness |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high together with in_valid |
| in_pixel | input | 32 | Framebuffer pixel, weight byte in [31:24] |
| in_row | input | ROW_W | Row of the pixel |
| in_col | input | COL_W | Column of the pixel |
| ovl_rd_en | output | 1 | Overlay memory read strobe |
| ovl_rd_addr | output | ADDR_W | Overlay memory byte address |
| ovl_rd_data | input | 24 | Colour bytes of the overlay word, returned one clock after ovl_rd_en |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream can accept |
| out_rgb | output | 24 | Output colour |

## Verification
The framebuffer weight byte is swept over 0x00, 0xFF and a midpoint. These values separate a correct mix from one that swaps the two operands or that rounds instead of truncating. Pixels placed one step on either side of every window edge separate inclusive bounds from exclusive ones. A pixel covered by both windows, plus pixels covered by only one, shows whether the window priority and the second window's address offset are right. Changing the window settings with and without a frame-start pulse, dimming at a middle level and at level 0, and a three-deep stall under backpressure each check a separate path: shadow loading, the scaling table and its bypass, and ordered hold.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  // default brightness table: entry i = 16*i, entry at bits [8i+7:8i]
  localparam logic [127:0] DEF_BRIGHT_TBL = 128'hF0E0D0C0B0A090807060504030201000;

  // weighted mix of one channel, weight taken from the framebuffer
  function automatic logic [7:0] mix8(input logic [7:0] wt,
                                      input logic [7:0] fbc,
                                      input logic [7:0] ovc);
    logic [15:0] acc;
    acc = 16'(8'hFF - wt) * 16'(ovc) + 16'(wt) * 16'(fbc);
    return acc[15:8];
  endfunction

  // brightness scale of one channel
  function automatic logic [7:0] dim8(input logic [7:0] k,
                                      input logic [7:0] c);
    logic [15:0] p;
    p = 16'(k) * 16'(c);
    return p[15:8];
  endfunction
endpackage

// File: rtl/ovl_win_sel.sv
module ovl_win_sel #(
  parameter int ROW_W      = 11,
  parameter int COL_W      = 11,
  parameter int ADDR_W     = 24,
  parameter int NUM_WIN    = 2,
  parameter int WIN_STRIDE = 32'h0040_0000
) (
  input  logic [ROW_W-1:0]         row,
  input  logic [COL_W-1:0]         col,
  input  logic [NUM_WIN-1:0]       en,
  input  logic [NUM_WIN*ROW_W-1:0] top,
  input  logic [NUM_WIN*COL_W-1:0] left,
  input  logic [NUM_WIN*COL_W-1:0] width,
  input  logic [NUM_WIN*ROW_W-1:0] height,
  output logic                     hit,
  output logic [ADDR_W-1:0]        addr
);
  localparam int LIN_W = ROW_W + COL_W + 1;

  logic [NUM_WIN-1:0] hit_w;
  logic [ADDR_W-1:0]  addr_w [NUM_WIN];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(w * WIN_STRIDE);
    logic [ROW_W-1:0] t, h, rel_r;
    logic [COL_W-1:0] l, wd, rel_c;
    logic [ROW_W:0]   r_end;
    logic [COL_W:0]   c_end;
    logic [LIN_W-1:0] lin;
    assign t     = top[w*ROW_W +: ROW_W];
    assign h     = height[w*ROW_W +: ROW_W];
    assign l     = left[w*COL_W +: COL_W];
    assign wd    = width[w*COL_W +: COL_W];
    assign r_end = {1'b0, t} + {1'b0, h};
    assign c_end = {1'b0, l} + {1'b0, wd};
    assign hit_w[w] = en[w] && (row >= t) && ({1'b0, row} < r_end)
                            && (col >= l) && ({1'b0, col} < c_end);
    assign rel_r = row - t;
    assign rel_c = col - l;
    assign lin   = LIN_W'(rel_r) * LIN_W'(wd) + LIN_W'(rel_c);
    assign addr_w[w] = BASE + ADDR_W'({lin, 2'b00});
  end

  // later windows are evaluated after earlier ones and replace them
  always_comb begin
    hit  = 1'b0;
    addr = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (hit_w[i]) begin
        hit  = 1'b1;
        addr = addr_w[i];
      end
    end
  end
endmodule

// File: rtl/ovl_mix.sv
module ovl_mix import ovl_pkg::*; (
  input  logic [31:0] fb,
  input  logic [23:0] ov,
  input  logic        hit,
  output logic [23:0] rgb
);
  for (genvar ch = 0; ch < 3; ch++) begin : g_ch
    assign rgb[8*ch +: 8] = hit ? mix8(fb[31:24], fb[8*ch +: 8], ov[8*ch +: 8])
                                : fb[8*ch +: 8];
  end
endmodule

// File: rtl/ovl_dim.sv
module ovl_dim import ovl_pkg::*; #(
  parameter int LVL_W = 4,
  parameter logic [8*(2**LVL_W)-1:0] BRIGHT_TBL = DEF_BRIGHT_TBL
) (
  input  logic [LVL_W-1:0] level,
  input  logic [23:0]      rgb_in,
  output logic [23:0]      rgb_out
);
  localparam logic [LVL_W-1:0] MAX_LVL = {LVL_W{1'b1}};

  logic [7:0] k;
  assign k = BRIGHT_TBL[8*level +: 8];

  for (genvar ch = 0; ch < 3; ch++) begin : g_ch
    assign rgb_out[8*ch +: 8] = (level == MAX_LVL) ? rgb_in[8*ch +: 8]
                                                   : dim8(k, rgb_in[8*ch +: 8]);
  end
endmodule

// File: rtl/ovl_blend_dim.sv
module ovl_blend_dim import ovl_pkg::*; #(
  parameter int ROW_W      = 11,
  parameter int COL_W      = 11,
  parameter int ADDR_W     = 24,
  parameter int NUM_WIN    = 2,
  parameter int WIN_STRIDE = 32'h0040_0000,
  parameter int LVL_W      = 4,
  parameter logic [8*(2**LVL_W)-1:0] BRIGHT_TBL = DEF_BRIGHT_TBL
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     frame_start,
  input  logic [NUM_WIN-1:0]       win_en,
  input  logic [NUM_WIN*ROW_W-1:0] win_top,
  input  logic [NUM_WIN*COL_W-1:0] win_left,
  input  logic [NUM_WIN*COL_W-1:0] win_width,
  input  logic [NUM_WIN*ROW_W-1:0] win_height,
  input  logic [LVL_W-1:0]         dim_level,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [31:0]              in_pixel,
  input  logic [ROW_W-1:0]         in_row,
  input  logic [COL_W-1:0]         in_col,
  output logic                     ovl_rd_en,
  output logic [ADDR_W-1:0]        ovl_rd_addr,
  input  logic [23:0]              ovl_rd_data,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [23:0]              out_rgb
);
  // shadow copies of the window settings, loaded at frame start
  logic [NUM_WIN-1:0]       win_en_q;
  logic [NUM_WIN*ROW_W-1:0] win_top_q, win_height_q;
  logic [NUM_WIN*COL_W-1:0] win_left_q, win_width_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_en_q     <= '0;
      win_top_q    <= '0;
      win_height_q <= '0;
      win_left_q   <= '0;
      win_width_q  <= '0;
    end else if (frame_start) begin
      win_en_q     <= win_en;
      win_top_q    <= win_top;
      win_height_q <= win_height;
      win_left_q   <= win_left;
      win_width_q  <= win_width;
    end
  end

  // whole pipeline moves together; stalls only when the output is blocked
  logic advance;
  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;

  logic              sel_hit;
  logic [ADDR_W-1:0] sel_addr;

  ovl_win_sel #(
    .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W),
    .NUM_WIN(NUM_WIN), .WIN_STRIDE(WIN_STRIDE)
  ) u_sel (
    .row(in_row), .col(in_col), .en(win_en_q),
    .top(win_top_q), .left(win_left_q),
    .width(win_width_q), .height(win_height_q),
    .hit(sel_hit), .addr(sel_addr)
  );

  assign ovl_rd_en   = advance && in_valid && sel_hit;
  assign ovl_rd_addr = sel_addr;

  // stage 1: pixel waits for overlay data; stage 2: mixed colour
  logic        v1_q, v2_q, hit1_q;
  logic [31:0] px1_q;
  logic [23:0] rgb2_q, mix_rgb, dim_rgb;

  ovl_mix u_mix (.fb(px1_q), .ov(ovl_rd_data), .hit(hit1_q), .rgb(mix_rgb));

  ovl_dim #(.LVL_W(LVL_W), .BRIGHT_TBL(BRIGHT_TBL)) u_dim (
    .level(dim_level), .rgb_in(rgb2_q), .rgb_out(dim_rgb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      v1_q      <= 1'b0;
      v2_q      <= 1'b0;
      out_valid <= 1'b0;
    end else if (advance) begin
      v1_q      <= in_valid;
      v2_q      <= v1_q;
      out_valid <= v2_q;
    end
  end

  always_ff @(posedge clk) begin
    if (advance) begin
      px1_q   <= in_pixel;
      hit1_q  <= in_valid && sel_hit;
      rgb2_q  <= mix_rgb;
      out_rgb <= dim_rgb;
    end
  end
endmodule

// File: rtl/ovl_blend_dim_chk.sv
module ovl_blend_dim_chk #(
  parameter int ADDR_W  = 24,
  parameter int NUM_WIN = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               frame_start,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [23:0]        out_rgb,
  input logic               ovl_rd_en,
  input logic [ADDR_W-1:0]  ovl_rd_addr,
  input logic               v2_q,
  input logic [NUM_WIN-1:0] win_en_q
);
  // R1: output idle right after reset
  a_r1_idle_after_reset: assert property (@(posedge clk)
    $past(rst) |-> !out_valid);

  // R2: a beat reaches the output only from the stage before it
  a_r2_from_stage2: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(v2_q));

  // R7: overlay reads are word aligned
  a_r7_word_aligned: assert property (@(posedge clk) disable iff (rst)
    ovl_rd_en |-> (ovl_rd_addr[1:0] == 2'b00));

  // R7: no read while blocked, so the held data stays valid
  a_r7_no_read_in_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !ovl_rd_en);

  // R10: shadow enables change only on a frame-start edge
  a_r10_shadow_stable: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(win_en_q));

  // R11: blocked output holds
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_rgb)));

  // R11: input blocked only under output backpressure
  a_r11_ready_low: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> (out_valid && !out_ready));
endmodule

bind ovl_blend_dim ovl_blend_dim_chk #(.ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN)) u_chk (
  .clk(clk), .rst(rst), .frame_start(frame_start), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_rgb(out_rgb),
  .ovl_rd_en(ovl_rd_en), .ovl_rd_addr(ovl_rd_addr),
  .v2_q(v2_q), .win_en_q(win_en_q)
);

// File: tb/ovl_blend_dim_bench.sv
module ovl_blend_dim_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_start = 1'b0;
  logic [1:0]  win_en = '0;
  logic [21:0] win_top = '0, win_left = '0, win_width = '0, win_height = '0;
  logic [3:0]  dim_level = 4'd15;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_pixel = '0;
  logic [10:0] in_row = '0, in_col = '0;
  logic        ovl_rd_en;
  logic [23:0] ovl_rd_addr;
  logic [23:0] ovl_rd_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [23:0] out_rgb;

  int n_tests = 0;
  int n_fail  = 0;
  int m_en[2], m_top[2], m_left[2], m_wd[2], m_ht[2];

  always #5 clk = ~clk;

  ovl_blend_dim u_ovl_blend_dim (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .win_en(win_en), .win_top(win_top), .win_left(win_left),
    .win_width(win_width), .win_height(win_height), .dim_level(dim_level),
    .in_valid(in_valid), .in_ready(in_ready), .in_pixel(in_pixel),
    .in_row(in_row), .in_col(in_col),
    .ovl_rd_en(ovl_rd_en), .ovl_rd_addr(ovl_rd_addr), .ovl_rd_data(ovl_rd_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_rgb(out_rgb)
  );

  // overlay memory model: pattern derived from the address, holds when idle
  function automatic logic [23:0] memf(input logic [23:0] a);
    return {a[9:2] ^ a[23:16], a[17:10] + 8'h33, a[9:2] ^ 8'hA5};
  endfunction

  always_ff @(posedge clk) if (ovl_rd_en) ovl_rd_data <= memf(ovl_rd_addr);

  function automatic logic [23:0] expect_rgb(input logic [31:0] pix, input int row,
                                             input int col, input int lvl);
    int sel = -1;
    int a, fc, oc, r;
    logic [31:0] addr;
    logic [23:0] ov, res;
    for (int w = 0; w < 2; w++)
      if (m_en[w] != 0 && row >= m_top[w] && row < m_top[w] + m_ht[w] &&
          col >= m_left[w] && col < m_left[w] + m_wd[w]) sel = w;
    res = pix[23:0];
    if (sel >= 0) begin
      addr = 32'(sel * 32'h400000 + ((row - m_top[sel]) * m_wd[sel] + (col - m_left[sel])) * 4);
      ov = memf(addr[23:0]);
      a = int'(pix[31:24]);
      for (int ch = 0; ch < 3; ch++) begin
        fc = int'(pix[8*ch +: 8]);
        oc = int'(ov[8*ch +: 8]);
        r  = ((255 - a) * oc + a * fc) >> 8;
        res[8*ch +: 8] = 8'(r);
      end
    end
    if (lvl != 15)
      for (int ch = 0; ch < 3; ch++) begin
        r = (lvl * 16 * int'(res[8*ch +: 8])) >> 8;
        res[8*ch +: 8] = 8'(r);
      end
    return res;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_win(input int w, input int en, input int top, input int left,
                         input int wd, input int ht, input bit pulse);
    @(negedge clk);
    win_en[w]             = en[0];
    win_top[w*11 +: 11]   = 11'(top);
    win_left[w*11 +: 11]  = 11'(left);
    win_width[w*11 +: 11] = 11'(wd);
    win_height[w*11 +: 11]= 11'(ht);
    if (pulse) begin
      frame_start = 1'b1;
      m_en[w] = en; m_top[w] = top; m_left[w] = left; m_wd[w] = wd; m_ht[w] = ht;
      @(negedge clk);
      frame_start = 1'b0;
    end
  endtask

  // one pixel through an empty pipeline, output sampled at negedges
  task automatic px(input string req, input logic [31:0] pix, input int row, input int col);
    logic [23:0] e;
    e = expect_rgb(pix, row, col, int'(dim_level));
    @(negedge clk);
    in_valid = 1'b1; in_pixel = pix; in_row = 11'(row); in_col = 11'(col);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk({req, " R2 not yet valid"}, 32'(out_valid), 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk({req, " R2 valid"}, 32'(out_valid), 32'd1);
    chk({req, " rgb"}, 32'(out_rgb), 32'(e));
  endtask

  task automatic t_reset;
    chk("R1 out_valid", 32'(out_valid), 32'd0);
    chk("R1 in_ready", 32'(in_ready), 32'd1);
    chk("R1 ovl_rd_en", 32'(ovl_rd_en), 32'd0);
    // settings driven but never loaded: windows stay off (R1)
    set_win(0, 1, 0, 0, 100, 100, 1'b0);
    px("R1 windows off", 32'h80_123456, 5, 5);
  endtask

  task automatic t_pass;
    px("R6 pass a00", 32'h00_A1B2C3, 200, 300);
    px("R6 pass aFF", 32'hFF_0F1E2D, 0, 0);
  endtask

  task automatic t_blend;
    set_win(0, 1, 10, 20, 8, 4, 1'b1);
    px("R5 R7 a00", 32'h00_112233, 11, 22);
    px("R5 R7 aFF", 32'hFF_112233, 11, 22);
    px("R5 R7 a80", 32'h80_F0A050, 12, 25);
  endtask

  task automatic t_edges;
    px("R3 top-left in", 32'h00_010203, 10, 20);
    px("R3 bottom-right in", 32'h00_010203, 13, 27);
    px("R3 row end out", 32'h00_010203, 14, 20);
    px("R3 row above out", 32'h00_010203, 9, 20);
    px("R3 col end out", 32'h00_010203, 10, 28);
    px("R3 col left out", 32'h00_010203, 10, 19);
  endtask

  task automatic t_power;
    set_win(0, 0, 10, 20, 8, 4, 1'b1);
    px("R4 disabled", 32'h40_445566, 11, 22);
  endtask

  task automatic t_overlap;
    set_win(0, 1, 10, 20, 8, 4, 1'b1);
    set_win(1, 1, 12, 24, 6, 5, 1'b1);
    px("R8 both windows", 32'h20_778899, 12, 25);
    px("R8 window0 only", 32'h20_778899, 11, 25);
    px("R7 window1 only", 32'h10_778899, 15, 29);
  endtask

  task automatic t_dim;
    dim_level = 4'd5;
    px("R9 level5 overlay", 32'h60_C0C0C0, 12, 25);
    px("R9 level5 plain", 32'h00_FF80FF, 300, 300);
    dim_level = 4'd0;
    px("R9 level0", 32'h00_FFFFFF, 300, 300);
    dim_level = 4'd15;
    px("R9 level15", 32'h00_FFFFFF, 300, 300);
  endtask

  task automatic t_shadow;
    set_win(1, 1, 100, 100, 4, 4, 1'b0);
    px("R10 unloaded old", 32'h00_123456, 12, 25);
    px("R10 unloaded new", 32'h00_123456, 101, 101);
    @(negedge clk); frame_start = 1'b1;
    m_en[1] = 1; m_top[1] = 100; m_left[1] = 100; m_wd[1] = 4; m_ht[1] = 4;
    @(negedge clk); frame_start = 1'b0;
    px("R10 loaded old", 32'h00_123456, 12, 25);
    px("R10 loaded new", 32'h00_123456, 101, 101);
  endtask

  task automatic t_stall;
    logic [23:0] ea, eb, ec;
    ea = expect_rgb(32'h30_102030, 11, 21, 15);
    eb = expect_rgb(32'h90_405060, 101, 102, 15);
    ec = expect_rgb(32'h00_708090, 12, 23, 15);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_pixel = 32'h30_102030; in_row = 11; in_col = 21;
    @(negedge clk);
    in_pixel = 32'h90_405060; in_row = 101; in_col = 102;
    @(negedge clk);
    in_pixel = 32'h00_708090; in_row = 12; in_col = 23;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11 A valid", 32'(out_valid), 32'd1);
    chk("R11 A rgb", 32'(out_rgb), 32'(ea));
    chk("R11 in_ready low", 32'(in_ready), 32'd0);
    repeat (3) @(negedge clk);
    chk("R11 A held", 32'(out_rgb), 32'(ea));
    out_ready = 1'b1;
    @(negedge clk);
    chk("R11 B rgb", 32'(out_rgb), 32'(eb));
    @(negedge clk);
    chk("R11 C rgb", 32'(out_rgb), 32'(ec));
    @(negedge clk);
    chk("R11 drained", 32'(out_valid), 32'd0);
  endtask

  initial begin
    for (int w = 0; w < 2; w++) begin
      m_en[w] = 0; m_top[w] = 0; m_left[w] = 0; m_wd[w] = 0; m_ht[w] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_pass;
    t_blend;
    t_edges;
    t_power;
    t_overlap;
    t_dim;
    t_shadow;
    t_stall;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule